// File: doc/BRIEF.md
# Title-Select Cartridge Resource Mapper

This block sits between the console's cartridge window and the cartridge's storage. An 8 KB window is presented to the processor. A write into the lowest bytes of that window is a select write: the data is ignored, and the even address carries an index. While the mapper is in menu mode, that index is a title number. The mapper then reads a 4-byte descriptor for that title from an on-chip table and sets up the cartridge resources from it. These resources are the flash sector that backs the ROM window, how many banks the title may switch between, where its graphics-ROM content starts, and whether battery-free RAM replaces all or half of the window.

Flash placement is indirect. A title's sector comes from its descriptor, so images can sit in flash in any order. Once a title is running, the select index becomes a bank number, but only if the descriptor allows live switching. Otherwise select writes and every other write into ROM are ignored. This protects titles that poke ROM for copy protection or through faulty code. A simple byte-wide port fills the table. The table is not cleared by reset, so it survives a console reset.

The descriptor is laid out as follows:

| Byte | Bits | Meaning |
|------|------|---------|
| 0 | all | ROM base sector |
| 1 | all | graphics-ROM base chunk |
| 2 | 1:0 | bank count minus one |
| 3 | bit 0 | live switching allowed |
| 3 | bit 1 | RAM enabled |
| 3 | bit 2 | split window (ROM low half, RAM high half) |
| 3 | bit 3 | graphics-ROM present |

Top module: `title_mapper`

## Requirements
- R1: After reset the mapper is in menu mode. A window read asserts rom_cs with rom_addr equal to the window offset (sector 0). ram_cs and grom_en are low, and ready is high.
- R2: A write with offset below 256 is a select write. In menu mode it starts a lookup of the title given by offset bits 7:1.
- R3: A lookup lasts LOOKUP_CYC cycles. During it rom_cs and ram_cs stay low, and ready is low exactly when a read is requested.
- R4: After the lookup, a ROM read is served from the sector in descriptor byte 0 (low 6 bits), bank offset 0. rom_addr is {sector, offset}.
- R5: After the lookup, grom_base equals the low 6 bits of descriptor byte 1, and grom_en equals bit 3 of byte 3.
- R6: When bit 0 of byte 3 is set, a select write latches bank b = offset bits 7:1. The sector becomes (base + b mod count) mod 64, where count = byte 2 bits 1:0 plus one.
- R7: When bit 0 of byte 3 is clear, select writes leave the ROM mapping unchanged.
- R8: rom_cs is never asserted during a write.
- R9: With RAM enabled and no split, reads anywhere in the window and writes at offsets 256 and above assert ram_cs with ram_addr equal to the offset. Writes below 256 never assert ram_cs.
- R10: With RAM enabled and split set, offsets with bit 12 set go to RAM and the rest go to ROM. Without RAM enabled, the whole window is ROM.
- R11: Leaving menu mode is permanent until reset: later select writes never reload a descriptor.
- R12: A table write stores tbl_wdata as byte tbl_addr[1:0] of the descriptor for title tbl_addr[8:2].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| tbl_we | input | 1 | descriptor table byte write |
| tbl_addr | input | 9 | table byte address (title, byte) |
| tbl_wdata | input | 8 | table byte data |
| cpu_rd | input | 1 | window read request |
| cpu_we | input | 1 | window write request |
| cpu_addr | input | 13 | byte offset in the window |
| ready | output | 1 | low holds the console during a lookup |
| rom_cs | output | 1 | ROM flash select |
| rom_addr | output | 19 | ROM flash byte address |
| ram_cs | output | 1 | RAM select |
| ram_addr | output | 13 | RAM byte address |
| grom_en | output | 1 | graphics-ROM content present |
| grom_base | output | 6 | graphics-ROM base chunk |

## Verification
Every cycle, the assertions check the following:
- the chip selects stay quiet and ready drops for reads while a lookup is pending;
- the two selects are never active together;
- low-zone writes never reach RAM or ROM;
- menu mode is never re-entered;
- the bank offset stays within the title's count and freezes when switching is off.

Only the bench's sweep shows that the right descriptor lands in the right place. It runs every one of the 128 titles through reset, selection, bank writes and RAM accesses, with every flag combination. This covers the sector arithmetic with wraparound, the modulo on bank numbers, and the split window boundary.

// File: rtl/tmap_pkg.sv
package tmap_pkg;
   // byte 0 sits in the low bits
   typedef struct packed {
      logic [7:0] flags;
      logic [7:0] span;
      logic [7:0] gbase;
      logic [7:0] rbase;
   } tdesc_t;

   localparam int FLG_LIVE  = 0;
   localparam int FLG_RAM   = 1;
   localparam int FLG_SPLIT = 2;
   localparam int FLG_GROM  = 3;
endpackage

// File: rtl/tmap_table.sv
module tmap_table
   import tmap_pkg::*;
#(
   parameter int IDX_W = 7
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [IDX_W+1:0] wr_addr,
   input  logic [7:0]       wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output tdesc_t           rd_desc
);
   localparam int TITLES = 2 ** IDX_W;

   logic [7:0] lane_q [4];

   // one byte-wide store per descriptor byte
   for (genvar g = 0; g < 4; g++) begin : g_lane
      logic [7:0] mem [TITLES];
      always_ff @(posedge clk) begin
         if (wr_en && wr_addr[1:0] == 2'(g))
            mem[wr_addr[IDX_W+1:2]] <= wr_data;
      end
      assign lane_q[g] = mem[rd_idx];
   end

   assign rd_desc = {lane_q[3], lane_q[2], lane_q[1], lane_q[0]};
endmodule

// File: rtl/tmap_seq.sv
module tmap_seq
   import tmap_pkg::*;
#(
   parameter int IDX_W      = 7,
   parameter int LOOKUP_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_wr,
   input  logic [IDX_W-1:0] sel_idx,
   input  tdesc_t           desc_in,
   output logic [IDX_W-1:0] rd_idx,
   output logic             busy,
   output logic             menu,
   output tdesc_t           act,
   output logic [1:0]       bank_off
);
   localparam int CNT_W = $clog2(LOOKUP_CYC + 1);

   typedef enum logic [1:0] {S_MENU, S_LOOK, S_RUN} st_t;
   st_t              st;
   logic [CNT_W-1:0] cnt;
   logic [IDX_W-1:0] span_n;
   logic [1:0]       off_nx;

   assign span_n = IDX_W'(act.span[1:0]) + IDX_W'(1);
   assign off_nx = 2'(sel_idx % span_n);
   assign busy   = (st == S_LOOK);
   assign menu   = (st == S_MENU);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= S_MENU;
         cnt      <= '0;
         rd_idx   <= '0;
         act      <= '0;
         bank_off <= '0;
      end else begin
         case (st)
            S_MENU: if (sel_wr) begin
               rd_idx <= sel_idx;
               cnt    <= CNT_W'(LOOKUP_CYC - 1);
               st     <= S_LOOK;
            end
            S_LOOK: if (cnt == '0) begin
               act      <= desc_in;
               bank_off <= '0;
               st       <= S_RUN;
            end else begin
               cnt <= cnt - 1'b1;
            end
            S_RUN: if (sel_wr && act.flags[FLG_LIVE])
               bank_off <= off_nx;
            default: st <= S_MENU;
         endcase
      end
   end

   AST_MENU_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st != S_MENU) |=> (st != S_MENU)); // R11
   AST_BANK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_RUN && !act.flags[FLG_LIVE]) |=> $stable(bank_off)); // R7
   AST_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_RUN) |-> (bank_off <= act.span[1:0])); // R6
   AST_LOOKUP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt < CNT_W'(LOOKUP_CYC))); // R3
endmodule

// File: rtl/tmap_decode.sv
module tmap_decode
   import tmap_pkg::*;
#(
   parameter int WIN_AW      = 13,
   parameter int SEL_BYTES   = 256,
   parameter int SECT_W      = 6,
   parameter int GCH_W       = 6,
   parameter bit ALLOW_SPLIT = 1'b1
) (
   input  logic                     cpu_rd,
   input  logic                     cpu_we,
   input  logic [WIN_AW-1:0]        cpu_addr,
   input  logic                     busy,
   input  logic                     menu,
   input  tdesc_t                   act,
   input  logic [1:0]               bank_off,
   output logic                     sel_wr,
   output logic                     ready,
   output logic                     rom_cs,
   output logic [SECT_W+WIN_AW-1:0] rom_addr,
   output logic                     ram_cs,
   output logic [WIN_AW-1:0]        ram_addr,
   output logic                     grom_en,
   output logic [GCH_W-1:0]         grom_base
);
   localparam int SEL_AW = $clog2(SEL_BYTES);

   logic              low_zone, ram_on, split, ram_zone;
   logic [SECT_W-1:0] sector;
   logic              unused_desc;

   assign unused_desc = ^act;
   assign low_zone    = (cpu_addr[WIN_AW-1:SEL_AW] == '0);
   assign sel_wr      = cpu_we && low_zone && !busy;
   assign ram_on      = !menu && !busy && act.flags[FLG_RAM];

   if (ALLOW_SPLIT) begin : g_split
      assign split = act.flags[FLG_SPLIT];
   end else begin : g_nosplit
      assign split = 1'b0;
   end

   assign ram_zone = ram_on && (!split || cpu_addr[WIN_AW-1]);
   assign ram_cs   = ram_zone && (cpu_rd || (cpu_we && !low_zone));
   assign ram_addr = cpu_addr;
   assign rom_cs   = !busy && cpu_rd && !ram_zone;
   assign sector   = menu ? '0 : act.rbase[SECT_W-1:0] + SECT_W'(bank_off);
   assign rom_addr = {sector, cpu_addr};
   assign ready    = !(busy && cpu_rd);

   assign grom_en   = !menu && act.flags[FLG_GROM];
   assign grom_base = menu ? '0 : act.gbase[GCH_W-1:0];
endmodule

// File: rtl/title_mapper.sv
module title_mapper
   import tmap_pkg::*;
#(
   parameter int WIN_AW      = 13,
   parameter int SEL_BYTES   = 256,
   parameter int SECT_W      = 6,
   parameter int GCH_W       = 6,
   parameter int LOOKUP_CYC  = 2,
   parameter bit ALLOW_SPLIT = 1'b1,
   localparam int IDX_W      = $clog2(SEL_BYTES) - 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tbl_we,
   input  logic [IDX_W+1:0]         tbl_addr,
   input  logic [7:0]               tbl_wdata,
   input  logic                     cpu_rd,
   input  logic                     cpu_we,
   input  logic [WIN_AW-1:0]        cpu_addr,
   output logic                     ready,
   output logic                     rom_cs,
   output logic [SECT_W+WIN_AW-1:0] rom_addr,
   output logic                     ram_cs,
   output logic [WIN_AW-1:0]        ram_addr,
   output logic                     grom_en,
   output logic [GCH_W-1:0]         grom_base
);
   if (LOOKUP_CYC < 1) begin : g_chk_lk
      $error("LOOKUP_CYC must be at least 1");
   end
   if (SECT_W < 2 || SECT_W > 8 || GCH_W > 8) begin : g_chk_w
      $error("sector and chunk widths must fit one descriptor byte");
   end
   if (IDX_W < 3 || SEL_BYTES != 2 ** (IDX_W + 1) || SEL_BYTES >= 2 ** (WIN_AW - 1)) begin : g_chk_sel
      $error("select zone must be a power of two inside the low half of the window");
   end

   tdesc_t           tbl_q, act;
   logic [IDX_W-1:0] rd_idx;
   logic             busy, menu, sel_wr;
   logic [1:0]       bank_off;

   tmap_table #(.IDX_W(IDX_W)) u_table (
      .clk(clk), .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_data(tbl_wdata),
      .rd_idx(rd_idx), .rd_desc(tbl_q)
   );

   tmap_seq #(.IDX_W(IDX_W), .LOOKUP_CYC(LOOKUP_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_idx(cpu_addr[IDX_W:1]),
      .desc_in(tbl_q), .rd_idx(rd_idx), .busy(busy), .menu(menu),
      .act(act), .bank_off(bank_off)
   );

   tmap_decode #(
      .WIN_AW(WIN_AW), .SEL_BYTES(SEL_BYTES), .SECT_W(SECT_W),
      .GCH_W(GCH_W), .ALLOW_SPLIT(ALLOW_SPLIT)
   ) u_dec (
      .cpu_rd(cpu_rd), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .busy(busy),
      .menu(menu), .act(act), .bank_off(bank_off), .sel_wr(sel_wr),
      .ready(ready), .rom_cs(rom_cs), .rom_addr(rom_addr), .ram_cs(ram_cs),
      .ram_addr(ram_addr), .grom_en(grom_en), .grom_base(grom_base)
   );

   AST_LOOKUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!rom_cs && !ram_cs)); // R3
   AST_LOOKUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cpu_rd) |-> !ready); // R3
   AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && !cpu_rd) |-> !rom_cs); // R8
   AST_SEL_NOT_RAM: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && !cpu_rd && cpu_addr < WIN_AW'(SEL_BYTES)) |-> !ram_cs); // R9
   AST_CS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rom_cs && ram_cs)); // R10
   AST_MENU_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
      menu |-> (!ram_cs && !grom_en)); // R1
endmodule

// File: tb/title_mapper_tb.sv
module title_mapper_tb;
   localparam int LK = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tbl_we = 1'b0;
   logic [8:0]  tbl_addr = '0;
   logic [7:0]  tbl_wdata = '0;
   logic        cpu_rd = 1'b0, cpu_we = 1'b0;
   logic [12:0] cpu_addr = '0;
   logic        ready, rom_cs, ram_cs, grom_en;
   logic [18:0] rom_addr;
   logic [12:0] ram_addr;
   logic [5:0]  grom_base;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   title_mapper #(.LOOKUP_CYC(LK)) u_dut (
      .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
      .tbl_wdata(tbl_wdata), .cpu_rd(cpu_rd), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .ready(ready), .rom_cs(rom_cs),
      .rom_addr(rom_addr), .ram_cs(ram_cs), .ram_addr(ram_addr),
      .grom_en(grom_en), .grom_base(grom_base)
   );

   function automatic logic [7:0] dbyte(input int t, input int b);
      case (b)
         0: return 8'((t * 37 + 5) & 255);
         1: return 8'((t * 11 + 3) & 255);
         2: return 8'((t * 13 + 160) & 255);
         default: return 8'(8'h50 | (t & 15));
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input int a);
      cpu_we = 1'b0; cpu_rd = 1'b1; cpu_addr = 13'(a); #1;
   endtask

   task automatic wr(input int a);
      cpu_rd = 1'b0; cpu_we = 1'b1; cpu_addr = 13'(a); #1;
   endtask

   task automatic run_title(input int t);
      int  base  = dbyte(t, 0) & 63;
      int  cnt   = (dbyte(t, 2) & 3) + 1;
      int  fl    = dbyte(t, 3);
      bit  live  = fl[0];
      bit  ramf  = fl[1] && !fl[2];
      bit  ramh  = fl[1] && fl[2];
      int  bsel  = (t * 5 + 3) & 127;
      int  sect;
      rst_n = 1'b0; cpu_rd = 1'b0; cpu_we = 1'b0;
      tick(); tick();
      rst_n = 1'b1;
      // R1 menu state
      rd(12'h123);
      chk("R1 rom_cs", rom_cs, 1);
      chk("R1 rom_addr", rom_addr, 32'h123);
      chk("R1 ram/grom", {ram_cs, grom_en, ready}, 3'b001);
      // R2 select title t
      wr(t << 1);
      chk("R8 menu select write rom_cs", rom_cs, 0);
      tick();
      rd(12'h400);
      for (int i = 0; i < LK; i++) begin
         chk("R3 lookup quiet", {rom_cs, ram_cs, ready}, 3'b000);
         tick();
      end
      #1;
      // R4 R5 R12 descriptor applied
      if (ramf) begin
         chk("R9 full ram read", {ram_cs, rom_cs}, 2'b10);
         chk("R9 ram_addr", ram_addr, 32'h400);
      end else begin
         chk("R4 R2 R12 rom_cs", rom_cs, 1);
         chk("R4 R12 rom_addr", rom_addr, 32'((base << 13) | 32'h400));
      end
      chk("R5 grom_base", grom_base, 32'(dbyte(t, 1) & 63));
      chk("R5 grom_en", grom_en, 32'(fl[3]));
      chk("R3 ready after lookup", ready, 1);
      // R6 R7 R11 select write after launch
      wr(bsel << 1);
      chk("R8 select write rom_cs", rom_cs, 0);
      chk("R9 select write ram_cs", ram_cs, 0);
      tick();
      rd(12'h400);
      if (!ramf) begin
         sect = live ? ((base + (bsel % cnt)) & 63) : base;
         if (live) chk("R6 live bank sector", rom_addr, 32'((sect << 13) | 32'h400));
         else      chk("R7 R11 frozen sector", rom_addr, 32'((sect << 13) | 32'h400));
         chk("R11 no relookup", ready, 1);
      end else begin
         sect = base;
      end
      // R9 R10 RAM behaviour
      if (ramf) begin
         wr(12'h800);
         chk("R9 ram write high", {ram_cs, ram_addr}, {1'b1, 13'h800});
         rd(12'h010);
         chk("R9 ram read low", {ram_cs, ram_addr}, {1'b1, 13'h010});
         wr(12'h010);
         chk("R9 low write not ram", ram_cs, 0);
      end else if (ramh) begin
         rd(13'h1234);
         chk("R10 split ram half", {ram_cs, rom_cs, ram_addr}, {2'b10, 13'h1234});
         rd(13'h0234);
         chk("R10 split rom half", {ram_cs, rom_cs}, 2'b01);
         wr(13'h1500);
         chk("R10 split ram write", {ram_cs, rom_cs}, 2'b10);
      end else begin
         rd(13'h1234);
         chk("R10 no ram all rom", {ram_cs, rom_cs}, 2'b01);
         chk("R10 rom_addr high", rom_addr, 32'((sect << 13) | 32'h1234));
         wr(13'h1234);
         chk("R8 rom write ignored", {rom_cs, ram_cs}, 2'b00);
      end
      tick();
      cpu_rd = 1'b0; cpu_we = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // R12 fill the descriptor table
      for (int a = 0; a < 512; a++) begin
         tbl_we = 1'b1; tbl_addr = 9'(a); tbl_wdata = dbyte(a >> 2, a & 3);
         tick();
      end
      tbl_we = 1'b0;
      for (int t = 0; t < 128; t++) run_title(t);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule